// File: doc/BRIEF.md
# Multicast-Queue Shared-Buffer Output Scheduler

This block is the queueing core of a small cell switch. Its output ports all draw on one shared cell buffer. Each clock cycle is one cell slot. In each slot every input port may present one cell. A cell is either unicast, carrying an output index, or multicast, carrying an output bitmap that an upstream routing lookup produced. Accepted cells go into any free buffer slot.

A unicast cell is linked onto the logical queue of its output. Every multicast cell is linked onto one common multicast queue, whatever its bitmap holds. On the output side, each port offers at most one cell per slot. It takes either the head of its own unicast queue or the head of the multicast queue, when that head still names the port in its remaining bitmap. Each output has its own valid/ready pair. A cell leaves an output only on a slot where valid and ready are both high.

Back-pressure rules:
- While ready is low, the cell stays queued and the output keeps offering a cell. The offered cell can change from unicast to multicast if a new multicast head claims that output.
- The input side has no ready. An arrival that finds no free slot is dropped, and the number of drops is reported one slot later.
- A mode pin chooses between strict multicast priority and per-output round-robin between the two classes.

Top module: `swq_sched`

## Requirements
- R1: After reset no output is valid, `drop_cnt` is 0, and all 16 buffer slots are free.
- R2: A unicast cell (`in_mc`=0) on input p is queued for the output given by `in_dest[p*2 +: 2]`. It is offered on that output from the slot after its arrival. Each output sends its unicast cells in arrival order. Cells that arrive in the same slot are ordered by ascending input index.
- R3: A multicast cell (`in_mc`=1) reaches output o when bit `in_map[p*4 + o]` is set. While the cell is the multicast head, it is offered with `out_mc`=1 on every output still set in its bitmap. Each output's copy is consumed by that output's own handshake, and the cell's slot is freed after the last copy leaves.
- R4: Only the multicast head is offered. A later multicast cell waits, even for outputs that the head does not use.
- R5: With `rr_mode`=0, an output claimed by the multicast head offers the multicast cell, even when unicast cells are waiting. A unicast cell is offered only when the multicast queue is empty or its head does not claim that output.
- R6: With `rr_mode`=1, an output where both classes are available alternates between them on each transfer, starting with multicast after reset. Its turn advances only on transfers where both classes were available.
- R7: A cell is consumed only when `out_valid` and `out_ready` are both high. While `out_ready` is low, the output stays valid and no cell is removed.
- R8: All 16 slots are shared by all outputs. In a slot, arrivals take free slots in ascending input order. Arrivals beyond the free count are dropped. `drop_cnt` shows, in the next slot, how many cells were dropped.
- R9: A slot freed by a departure can be taken by an arrival in the following slot.
- R10: A multicast arrival with an all-zero bitmap is discarded. It takes no slot and is not counted in `drop_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one cell slot |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 0 = strict multicast priority, 1 = round-robin between classes |
| in_valid | input | 4 | Arrival present on each input port |
| in_mc | input | 4 | Arrival is multicast |
| in_dest | input | 8 | Unicast output index, 2 bits per input |
| in_map | input | 16 | Multicast output bitmap, 4 bits per input |
| in_data | input | 32 | Cell payload, 8 bits per input |
| out_valid | output | 4 | Output offers a cell |
| out_ready | input | 4 | Output accepts the offered cell |
| out_mc | output | 4 | Offered cell comes from the multicast queue |
| out_data | output | 32 | Offered cell payload, 8 bits per output |
| drop_cnt | output | 3 | Cells dropped in the previous slot |

## Verification
The hardest situation to reach is a multicast head that has been partly delivered. Some of its outputs have taken their copy, others are still stalled, and a second multicast cell waits behind it. The bench holds a chosen subset of `out_ready` bits low across several slots to reach this state. It then checks three things: the freed outputs fall back to unicast, the waiting multicast cell stays hidden, and it appears only once the last stalled output takes its copy. Filling the buffer exactly to its edge is also staged, with staggered arrival counts, so that a single slot has both accepted and dropped cells.

// File: rtl/swq_pkg.sv
package swq_pkg;
  localparam int unsigned DEF_PORTS  = 4;
  localparam int unsigned DEF_SLOTS  = 16;
  localparam int unsigned DEF_DATA_W = 8;

  // which class an output favours on its next contested slot
  typedef enum logic {
    CLS_UNI   = 1'b0,
    CLS_MULTI = 1'b1
  } cls_e;
endpackage

// File: rtl/swq_free_pool.sv
module swq_free_pool #(
  parameter int unsigned PORTS = 4,
  parameter int unsigned SLOTS = 16,
  localparam int unsigned AW = $clog2(SLOTS),
  localparam int unsigned DW = $clog2(PORTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PORTS-1:0]      req,
  input  logic [SLOTS-1:0]      release_mask,
  output logic [PORTS-1:0]      grant,
  output logic [PORTS*AW-1:0]   grant_slot,
  output logic [SLOTS-1:0]      free_mask,
  output logic [DW-1:0]         drop_cnt
);
  logic [SLOTS-1:0] free_q;
  logic [SLOTS-1:0] avail;
  logic [DW-1:0]    miss;

  // lowest free slot goes to the lowest requesting port
  always_comb begin
    avail      = free_q;
    grant      = '0;
    grant_slot = '0;
    miss       = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (req[p]) begin
        if (avail == '0) begin
          miss = miss + DW'(1);
        end else begin
          grant[p] = 1'b1;
          for (int j = SLOTS - 1; j >= 0; j--) begin
            if (avail[j]) grant_slot[p*AW +: AW] = AW'(j);
          end
          avail[grant_slot[p*AW +: AW]] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q   <= '1;
      drop_cnt <= '0;
    end else begin
      free_q   <= avail | release_mask;
      drop_cnt <= miss;
    end
  end

  assign free_mask = free_q;

  // a slot handed back must have been occupied
  assert_no_double_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (release_mask & free_q) == '0);
endmodule

// File: rtl/swq_out_arb.sv
module swq_out_arb
  import swq_pkg::*;
#(
  parameter int unsigned PORTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_mode,
  input  logic [PORTS-1:0] mc_claim,
  input  logic [PORTS-1:0] uc_avail,
  input  logic [PORTS-1:0] out_ready,
  output logic [PORTS-1:0] valid,
  output logic [PORTS-1:0] sel_mc
);
  cls_e turn_q [PORTS];

  for (genvar o = 0; o < PORTS; o++) begin : g_out
    logic contested;
    logic rr_fire;

    assign contested = mc_claim[o] & uc_avail[o];
    assign valid[o]  = mc_claim[o] | uc_avail[o];
    assign sel_mc[o] = contested ? (!rr_mode || turn_q[o] == CLS_MULTI) : mc_claim[o];
    assign rr_fire   = rr_mode & contested & out_ready[o];

    always_ff @(posedge clk) begin
      if (!rst_n)       turn_q[o] <= CLS_MULTI;
      else if (rr_fire) turn_q[o] <= sel_mc[o] ? CLS_UNI : CLS_MULTI;
    end

    // back-to-back contested round-robin transfers must switch class
    assert_rr_alt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_fire && $past(rr_fire)) |-> (sel_mc[o] != $past(sel_mc[o])));
  end
endmodule

// File: rtl/swq_sched.sv
module swq_sched
  import swq_pkg::*;
#(
  parameter int unsigned PORTS  = DEF_PORTS,
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned PW = $clog2(PORTS),
  localparam int unsigned DW = $clog2(PORTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rr_mode,
  input  logic [PORTS-1:0]      in_valid,
  input  logic [PORTS-1:0]      in_mc,
  input  logic [PORTS*PW-1:0]   in_dest,
  input  logic [PORTS*PORTS-1:0] in_map,
  input  logic [PORTS*DATA_W-1:0] in_data,
  output logic [PORTS-1:0]      out_valid,
  input  logic [PORTS-1:0]      out_ready,
  output logic [PORTS-1:0]      out_mc,
  output logic [PORTS*DATA_W-1:0] out_data,
  output logic [DW-1:0]         drop_cnt
);
  localparam int unsigned AW = $clog2(SLOTS);
  localparam int unsigned CW = $clog2(SLOTS + 1);
  localparam int unsigned QN = PORTS + 1;      // unicast queues + one multicast
  localparam int unsigned QW = $clog2(QN);

  logic [DATA_W-1:0] cell_mem [SLOTS];
  logic [AW-1:0]     link_q [SLOTS];
  logic [AW-1:0]     link_d [SLOTS];
  logic [PORTS-1:0]  dmap_q [SLOTS];
  logic [PORTS-1:0]  dmap_d [SLOTS];
  logic [AW-1:0]     hd_q [QN];
  logic [AW-1:0]     hd_d [QN];
  logic [AW-1:0]     tl_q [QN];
  logic [AW-1:0]     tl_d [QN];
  logic [CW-1:0]     cnt_q [QN];
  logic [CW-1:0]     cnt_d [QN];

  logic [AW-1:0]     mc_head;
  logic              mc_busy;
  logic [PORTS-1:0]  mc_claim, uc_avail, sel_mc, fire, mc_take, uc_take, mc_left;
  logic              mc_pop;
  logic [SLOTS-1:0]  release_mask, free_mask;
  logic [PORTS-1:0]  req, grant;
  logic [PORTS*AW-1:0] grant_slot;
  logic [AW-1:0]     ar_slot;
  logic [QW-1:0]     ar_q;

  assign mc_head  = hd_q[PORTS];
  assign mc_busy  = cnt_q[PORTS] != '0;
  assign mc_claim = mc_busy ? dmap_q[mc_head] : '0;

  always_comb begin
    for (int o = 0; o < PORTS; o++) uc_avail[o] = cnt_q[o] != '0;
  end

  swq_out_arb #(.PORTS(PORTS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rr_mode  (rr_mode),
    .mc_claim (mc_claim),
    .uc_avail (uc_avail),
    .out_ready(out_ready),
    .valid    (out_valid),
    .sel_mc   (sel_mc)
  );

  assign out_mc  = sel_mc & out_valid;
  assign fire    = out_valid & out_ready;
  assign mc_take = fire & sel_mc;
  assign uc_take = fire & ~sel_mc;
  assign mc_left = mc_claim & ~mc_take;
  assign mc_pop  = mc_busy && (mc_take != '0) && (mc_left == '0);

  always_comb begin
    release_mask = '0;
    for (int o = 0; o < PORTS; o++) begin
      out_data[o*DATA_W +: DATA_W] = cell_mem[sel_mc[o] ? mc_head : hd_q[o]];
      if (uc_take[o]) release_mask[hd_q[o]] = 1'b1;
    end
    if (mc_pop) release_mask[mc_head] = 1'b1;
  end

  // zero-bitmap multicast arrivals never ask for a slot
  always_comb begin
    for (int p = 0; p < PORTS; p++)
      req[p] = in_valid[p] & (~in_mc[p] | (in_map[p*PORTS +: PORTS] != '0));
  end

  swq_free_pool #(.PORTS(PORTS), .SLOTS(SLOTS)) u_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .release_mask(release_mask),
    .grant       (grant),
    .grant_slot  (grant_slot),
    .free_mask   (free_mask),
    .drop_cnt    (drop_cnt)
  );

  // pop first, then append this slot's arrivals in input order
  always_comb begin
    link_d  = link_q;
    dmap_d  = dmap_q;
    ar_slot = '0;
    ar_q    = '0;
    for (int q = 0; q < QN; q++) begin
      logic pop;
      pop = (q < PORTS) ? uc_take[q] : mc_pop;
      hd_d[q]  = pop ? link_q[hd_q[q]] : hd_q[q];
      tl_d[q]  = tl_q[q];
      cnt_d[q] = cnt_q[q] - CW'(pop);
    end
    if (mc_busy) dmap_d[mc_head] = mc_left;
    for (int p = 0; p < PORTS; p++) begin
      if (grant[p]) begin
        ar_slot = grant_slot[p*AW +: AW];
        ar_q    = in_mc[p] ? QW'(PORTS) : QW'(in_dest[p*PW +: PW]);
        if (cnt_d[ar_q] == '0) hd_d[ar_q] = ar_slot;
        else                   link_d[tl_d[ar_q]] = ar_slot;
        tl_d[ar_q]     = ar_slot;
        cnt_d[ar_q]    = cnt_d[ar_q] + CW'(1);
        dmap_d[ar_slot] = in_mc[p] ? in_map[p*PORTS +: PORTS] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < QN; q++) begin
        hd_q[q]  <= '0;
        tl_q[q]  <= '0;
        cnt_q[q] <= '0;
      end
    end else begin
      hd_q  <= hd_d;
      tl_q  <= tl_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    link_q <= link_d;
    dmap_q <= dmap_d;
    for (int p = 0; p < PORTS; p++)
      if (grant[p]) cell_mem[grant_slot[p*AW +: AW]] <= in_data[p*DATA_W +: DATA_W];
  end

  // every slot is either free or held by exactly one queue
  int occ;
  always_comb begin
    occ = 0;
    for (int q = 0; q < QN; q++) occ = occ + int'(cnt_q[q]);
  end

  assert_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ + $countones(free_mask)) == SLOTS);

  assert_hol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_busy && !mc_pop) |=> (hd_q[PORTS] == $past(hd_q[PORTS])));

  for (genvar o = 0; o < PORTS; o++) begin : g_chk
    assert_mc_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rr_mode && out_valid[o] && !out_mc[o]) |-> !mc_claim[o]);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> out_valid[o]);
  end
endmodule

// File: tb/sim_swq_sched.sv
module sim_swq_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rr_mode = 1'b0;
  logic [3:0]  in_valid = '0, in_mc = '0, out_ready = '0;
  logic [7:0]  in_dest = '0;
  logic [15:0] in_map = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  out_valid, out_mc;
  logic [31:0] out_data;
  logic [2:0]  drop_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swq_sched u0 (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode),
    .in_valid(in_valid), .in_mc(in_mc), .in_dest(in_dest), .in_map(in_map),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_mc(out_mc), .out_data(out_data), .drop_cnt(drop_cnt)
  );

  typedef struct packed {
    logic [3:0]  iv;
    logic [3:0]  im;
    logic [7:0]  dest;
    logic [15:0] map;
    logic [31:0] data;
    logic [3:0]  rdy;
    logic [3:0]  ev;
    logic [3:0]  em;
    logic [31:0] ed;
    logic [2:0]  drop;
  } vec_t;

  localparam int NV = 22;
  // each row: expected outputs seen before this row's inputs take effect
  localparam vec_t V [NV] = '{
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b1111, 4'b0000,4'b0000,32'h00000000,3'd0}, // 0 R1
    '{4'b1011,4'b0000,8'h0A,16'h0000,32'h33002211,4'b0000, 4'b0000,4'b0000,32'h00000000,3'd0}, // 1 R2
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b0000, 4'b0101,4'b0000,32'h00110033,3'd0}, // 2 R2
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b0000, 4'b0101,4'b0000,32'h00110033,3'd0}, // 3 R7
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b1111, 4'b0101,4'b0000,32'h00110033,3'd0}, // 4 R7
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b1111, 4'b0100,4'b0000,32'h00220000,3'd0}, // 5 R2
    '{4'b0111,4'b0010,8'h02,16'h00B0,32'h00554466,4'b0000, 4'b0000,4'b0000,32'h00000000,3'd0}, // 6 R2
    '{4'b0001,4'b0001,8'h00,16'h0004,32'h00000077,4'b0000, 4'b1111,4'b1011,32'h44664444,3'd0}, // 7 R3
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b0001, 4'b1111,4'b1011,32'h44664444,3'd0}, // 8 R4
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b1010, 4'b1111,4'b1010,32'h44664455,3'd0}, // 9 R3
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b0100, 4'b0101,4'b0100,32'h00770055,3'd0}, // 10 R5
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b1111, 4'b0101,4'b0000,32'h00660055,3'd0}, // 11 R5
    '{4'b1111,4'b0000,8'hFF,16'h0000,32'h83828180,4'b0000, 4'b0000,4'b0000,32'h00000000,3'd0}, // 12 R3
    '{4'b1111,4'b0000,8'hFF,16'h0000,32'h87868584,4'b0000, 4'b1000,4'b0000,32'h80000000,3'd0}, // 13 R8
    '{4'b1111,4'b0000,8'hFF,16'h0000,32'h8B8A8988,4'b0000, 4'b1000,4'b0000,32'h80000000,3'd0}, // 14 R8
    '{4'b0011,4'b0000,8'hFF,16'h0000,32'h00008D8C,4'b0000, 4'b1000,4'b0000,32'h80000000,3'd0}, // 15 R8
    '{4'b1111,4'b0000,8'hFF,16'h0000,32'h91908F8E,4'b0000, 4'b1000,4'b0000,32'h80000000,3'd0}, // 16 R8
    '{4'b1111,4'b0000,8'hFF,16'h0000,32'h95949392,4'b0000, 4'b1000,4'b0000,32'h80000000,3'd2}, // 17 R8
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b1000, 4'b1000,4'b0000,32'h80000000,3'd4}, // 18 R8
    '{4'b1000,4'b0000,8'h40,16'h0000,32'hAB000000,4'b0000, 4'b1000,4'b0000,32'h81000000,3'd0}, // 19 R9
    '{4'b0001,4'b0001,8'h00,16'h0000,32'h000000EE,4'b0000, 4'b1010,4'b0000,32'h8100AB00,3'd0}, // 20 R9
    '{4'b0000,4'b0000,8'h00,16'h0000,32'h00000000,4'b0000, 4'b1010,4'b0000,32'h8100AB00,3'd0}  // 21 R10
  };

  function automatic string row_req(int i);
    case (i)
      0:                       return "R1";
      1, 2, 5, 6:              return "R2";
      7, 9, 12:                return "R3";
      8:                       return "R4";
      10, 11:                  return "R5";
      3, 4:                    return "R7";
      19, 20:                  return "R9";
      21:                      return "R10";
      default:                 return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = '0; in_mc = '0; in_dest = '0; in_map = '0; in_data = '0;
  endtask

  task automatic chk_lane(input string req, input int o, input logic v, input logic m, input logic [7:0] d);
    chk(req, $sformatf("out_valid[%0d]", o), 32'(out_valid[o]), 32'(v));
    if (v) begin
      chk(req, $sformatf("out_mc[%0d]", o), 32'(out_mc[o]), 32'(m));
      chk(req, $sformatf("out_data[%0d]", o), 32'(out_data[o*8 +: 8]), 32'(d));
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // vector walk, strict priority mode
    for (int i = 0; i < NV; i++) begin
      if (i != 0) @(negedge clk);
      for (int o = 0; o < 4; o++)
        chk_lane(row_req(i), o, V[i].ev[o], V[i].em[o], V[i].ed[o*8 +: 8]);
      chk(row_req(i), "drop_cnt", 32'(drop_cnt), 32'(V[i].drop));
      in_valid  = V[i].iv;
      in_mc     = V[i].im;
      in_dest   = V[i].dest;
      in_map    = V[i].map;
      in_data   = V[i].data;
      out_ready = V[i].rdy;
    end

    // R1: reset while the buffer is full empties everything
    @(negedge clk);
    idle_inputs();
    out_ready = '0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid after reset", 32'(out_valid), 32'h0);
    chk("R1", "drop_cnt after reset", 32'(drop_cnt), 32'h0);
    rst_n = 1'b1;

    // R6: round-robin on output 0, two unicast and two multicast cells
    rr_mode   = 1'b1;
    out_ready = 4'b0001;
    in_valid  = 4'b1111;
    in_mc     = 4'b1100;
    in_dest   = 8'h00;
    in_map    = 16'h1100;
    in_data   = 32'hB2B1A2A1;
    @(negedge clk);
    idle_inputs();
    chk("R1", "pool free after reset, drop_cnt", 32'(drop_cnt), 32'h0);
    chk_lane("R6", 0, 1'b1, 1'b1, 8'hB1);
    @(negedge clk);
    chk_lane("R6", 0, 1'b1, 1'b0, 8'hA1);
    @(negedge clk);
    chk_lane("R6", 0, 1'b1, 1'b1, 8'hB2);
    @(negedge clk);
    chk_lane("R6", 0, 1'b1, 1'b0, 8'hA2);
    @(negedge clk);
    chk("R6", "out_valid drained", 32'(out_valid), 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule